// File: doc/BRIEF.md
# Outbound Response Word Streamer

This block hands a response object, which firmware has already placed in private SRAM, to a system-side requester one 32-bit word at a time. Firmware supplies a word-aligned base address, an inclusive limit address, and the object length in words. It then pulses a go strobe. The block checks that the object fits inside the window before it accepts it. Once accepted, it fetches the first word from SRAM and raises the ready flag when that word has landed in its holding register.

The requester sees the held word on the read-data output. Looking at the word does not consume it. The requester consumes a word by writing any value to the read-data register with all four byte lanes enabled. That acknowledge moves the read pointer on by 4 bytes and starts a prefetch of the next word. The busy flag stays high until the next word arrives.

When the final word is acknowledged, ready drops and the pointer returns to the base address. If the object is empty, longer than the supported maximum, or runs past the limit, the block raises a one-cycle error pulse and does not set ready.

Top module: `mbx_outbound_reader`

## Requirements
- R1: After a synchronous reset, obj_ready_o, busy_o, err_o and mem_req_o are 0, and sys_rdata_o and rd_ptr_o are 0.
- R2: A go pulse with valid settings sets rd_ptr_o to the base address with its low 2 bits cleared, and raises busy_o in the cycle that follows. Once the SRAM word arrives, busy_o falls, obj_ready_o rises and sys_rdata_o shows the word stored at the base address.
- R3: Reads are not destructive: sys_rdata_o holds its word until an acknowledge is made. An acknowledge is sys_ack_i with sys_be_i equal to 4'b1111. It moves rd_ptr_o on by exactly 4, and after the prefetch sys_rdata_o shows the word at the new pointer.
- R4: A write to the read-data register with any byte-enable pattern other than 4'b1111 is ignored: the pointer, the word and the flags stay unchanged.
- R5: An acknowledge that arrives while busy_o is high is ignored, so no word is skipped.
- R6: Acknowledging the last word of the object clears obj_ready_o, returns rd_ptr_o to the base address and drives sys_rdata_o to 0.
- R7: While obj_ready_o is 0, sys_rdata_o reads 0 and acknowledges have no effect on the pointer or the flags.
- R8: A go pulse with an object size of 0 gives a single-cycle err_o pulse and starts neither a fetch nor ready.
- R9: A go pulse with a size above 1024 words (the size field is 11 bits wide) is rejected with err_o.
- R10: The object is accepted only if base + 4*(size-1) is no greater than the limit. This sum is computed without wrap-around. A last word that lands exactly on the limit is accepted.
- R11: A go pulse while an object is still in progress is ignored.
- R12: Each mem_req_o is a one-cycle pulse with a word-aligned mem_addr_o. Only one fetch is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_base_i | input | 32 | Window base byte address (low 2 bits ignored) |
| fw_limit_i | input | 32 | Inclusive address of the last word slot (low 2 bits ignored) |
| fw_size_i | input | 11 | Object length in 32-bit words |
| fw_go_i | input | 1 | Firmware strobe: object prepared |
| sys_ack_i | input | 1 | Requester write to the read-data register |
| sys_be_i | input | 4 | Byte enables of that write |
| sys_rdata_o | output | 32 | Value a read of the read-data register returns |
| obj_ready_o | output | 1 | Object available to the requester |
| busy_o | output | 1 | SRAM fetch in flight |
| err_o | output | 1 | One-cycle pulse on a rejected object |
| rd_ptr_o | output | 32 | Byte address of the current word |
| mem_req_o | output | 1 | SRAM read request pulse |
| mem_addr_o | output | 32 | SRAM read byte address |
| mem_rvalid_i | input | 1 | SRAM read data valid |
| mem_rdata_i | input | 32 | SRAM read data |

## Verification
The bench targets the following corner cases, and each one exposes a specific kind of faulty design:
- A window whose last word sits exactly on the limit: a design with an off-by-one limit check would reject it.
- A window whose end wraps past the top of the address space: a design using 32-bit arithmetic would accept it wrongly.
- Size 0 and size 1025: a design with a faulty range check would start streaming on either.
- A 1024-word object: a design with a narrow counter would end the object early.
- Acknowledges sent during a prefetch or with partial byte enables: a faulty design would skip or repeat words.
- Acknowledges and go pulses while idle or while an object is active: a faulty design would move the pointer or restart the object.
- After the final acknowledge, the pointer must read the base again: a design that misses this leaves the pointer one word past the end.

// File: rtl/mbx_outq_pkg.sv
package mbx_outq_pkg;
  typedef enum logic [1:0] {
    OQ_IDLE  = 2'd0,
    OQ_FETCH = 2'd1,
    OQ_HOLD  = 2'd2
  } oq_state_e;
endpackage

// File: rtl/mbx_outq_check.sv
// Accept/reject decision for a new outbound object: non-empty, within the
// maximum length, and last word inside the inclusive window (no wrap).
module mbx_outq_check #(
  parameter int AW        = 32,
  parameter int SIZE_W    = 11,
  parameter int MAX_WORDS = 1024
) (
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     limit_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              ok_o
);
  localparam int EW = AW + 1;

  logic [EW-1:0] base_ext, limit_ext, span, last_addr;

  always_comb begin
    base_ext  = {1'b0, base_i};
    limit_ext = {1'b0, limit_i};
    span      = EW'(size_i - SIZE_W'(1)) << 2;
    last_addr = base_ext + span;
    ok_o      = (size_i != '0) && (int'(size_i) <= MAX_WORDS) &&
                (last_addr <= limit_ext);
  end
endmodule

// File: rtl/mbx_outq_seq.sv
// Sequencer: pointer, remaining count, single-outstanding SRAM prefetch.
module mbx_outq_seq
  import mbx_outq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              go_ok_i,
  input  logic [AW-1:0]     base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              ack_i,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     word_o,
  output logic              hold_o,
  output logic              ready_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [AW-1:0]     ptr_o
);
  localparam logic [AW-1:0] STEP = AW'(4);

  oq_state_e         state_q;
  logic [AW-1:0]     ptr_q, base_q, addr_q;
  logic [SIZE_W-1:0] remain_q;
  logic [DW-1:0]     word_q;
  logic              ready_q, req_q, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= OQ_IDLE;
      ptr_q    <= '0;
      base_q   <= '0;
      addr_q   <= '0;
      remain_q <= '0;
      word_q   <= '0;
      ready_q  <= 1'b0;
      req_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      err_q <= 1'b0;
      unique case (state_q)
        OQ_IDLE: begin
          if (go_i) begin
            if (go_ok_i) begin
              base_q   <= base_i;
              ptr_q    <= base_i;
              remain_q <= size_i;
              req_q    <= 1'b1;
              addr_q   <= base_i;
              state_q  <= OQ_FETCH;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        OQ_FETCH: begin
          if (mem_rvalid_i) begin
            word_q  <= mem_rdata_i;
            ready_q <= 1'b1;
            state_q <= OQ_HOLD;
          end
        end
        OQ_HOLD: begin
          if (ack_i) begin
            if (remain_q == SIZE_W'(1)) begin
              remain_q <= '0;
              ready_q  <= 1'b0;
              ptr_q    <= base_q;
              word_q   <= '0;
              state_q  <= OQ_IDLE;
            end else begin
              remain_q <= remain_q - SIZE_W'(1);
              ptr_q    <= ptr_q + STEP;
              addr_q   <= ptr_q + STEP;
              req_q    <= 1'b1;
              state_q  <= OQ_FETCH;
            end
          end
        end
        default: state_q <= OQ_IDLE;
      endcase
    end
  end

  assign mem_req_o  = req_q;
  assign mem_addr_o = addr_q;
  assign word_o     = word_q;
  assign hold_o     = (state_q == OQ_HOLD);
  assign ready_o    = ready_q;
  assign busy_o     = (state_q == OQ_FETCH);
  assign err_o      = err_q;
  assign ptr_o      = ptr_q;

  // R3: within an active object the pointer only moves forward by one word
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ready_q && $past(ready_q) && (ptr_q != $past(ptr_q))) |-> (ptr_q == $past(ptr_q) + STEP));

  // R6: ready falls only together with the pointer returning to the base
  assert_ptr_home_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_q) |-> (ptr_q == base_q && state_q == OQ_IDLE));

  // R12: request is a single-cycle pulse
  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);

  // R12: request address is word aligned
  assert_req_align_R12: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (addr_q[1:0] == 2'b00));

  // R8: an error pulse never coincides with an active object
  assert_err_idle_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (!ready_q && state_q == OQ_IDLE));
endmodule

// File: rtl/mbx_outbound_reader.sv
module mbx_outbound_reader #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int SIZE_W    = 11,
  parameter int MAX_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     fw_base_i,
  input  logic [AW-1:0]     fw_limit_i,
  input  logic [SIZE_W-1:0] fw_size_i,
  input  logic              fw_go_i,
  input  logic              sys_ack_i,
  input  logic [DW/8-1:0]   sys_be_i,
  output logic [DW-1:0]     sys_rdata_o,
  output logic              obj_ready_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [AW-1:0]     rd_ptr_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

  logic [AW-1:0] base_al, limit_al;
  logic          go_ok, full_ack, hold;
  logic [DW-1:0] word;

  assign base_al  = fw_base_i & ALIGN_MASK;
  assign limit_al = fw_limit_i & ALIGN_MASK;
  assign full_ack = sys_ack_i && (sys_be_i == '1);

  mbx_outq_check #(.AW(AW), .SIZE_W(SIZE_W), .MAX_WORDS(MAX_WORDS)) u_check (
    .base_i  (base_al),
    .limit_i (limit_al),
    .size_i  (fw_size_i),
    .ok_o    (go_ok)
  );

  mbx_outq_seq #(.AW(AW), .DW(DW), .SIZE_W(SIZE_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .go_i         (fw_go_i),
    .go_ok_i      (go_ok),
    .base_i       (base_al),
    .size_i       (fw_size_i),
    .ack_i        (full_ack),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .word_o       (word),
    .hold_o       (hold),
    .ready_o      (obj_ready_o),
    .busy_o       (busy_o),
    .err_o        (err_o),
    .ptr_o        (rd_ptr_o)
  );

  assign sys_rdata_o = hold ? word : '0;

  // R7: nothing but zero is visible while no object is ready
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !obj_ready_o |-> (sys_rdata_o == '0));

  // R12: no new request while a fetch is still outstanding
  assert_one_fetch_R12: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !mem_rvalid_i && !$rose(busy_o)) |-> !mem_req_o);
endmodule

// File: tb/mbx_outbound_reader_tb_top.sv
`timescale 1ns/1ps
module mbx_outbound_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fw_base = '0, fw_limit = '0;
  logic [10:0] fw_size = '0;
  logic        fw_go = 1'b0, sys_ack = 1'b0;
  logic [3:0]  sys_be = 4'hF;
  logic [31:0] sys_rdata, rd_ptr, mem_addr;
  logic        obj_ready, busy, err, mem_req;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mbx_outbound_reader dut_i (
    .clk(clk), .rst(rst), .fw_base_i(fw_base), .fw_limit_i(fw_limit),
    .fw_size_i(fw_size), .fw_go_i(fw_go), .sys_ack_i(sys_ack), .sys_be_i(sys_be),
    .sys_rdata_o(sys_rdata), .obj_ready_o(obj_ready), .busy_o(busy), .err_o(err),
    .rd_ptr_o(rd_ptr), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] memval(input logic [31:0] a);
    return a ^ {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
  endfunction

  // SRAM model: one-cycle read latency
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= memval(mem_addr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
  endtask

  task automatic go(input logic [31:0] b, input logic [31:0] l, input int sz);
    fw_base = b; fw_limit = l; fw_size = 11'(sz); fw_go = 1'b1;
    @(negedge clk);
    fw_go = 1'b0;
  endtask

  task automatic ack(input logic [3:0] be);
    sys_ack = 1'b1; sys_be = be;
    @(negedge clk);
    sys_ack = 1'b0; sys_be = 4'hF;
  endtask

  task automatic expect_reject(input logic [31:0] b, input logic [31:0] l, input int sz, input string tag);
    logic [31:0] p0;
    p0 = rd_ptr;
    go(b, l, sz);
    chk(err == 1'b1, tag, 32'(err), 32'd1);
    chk(!busy && !obj_ready && rd_ptr == p0, tag, rd_ptr, p0);
    @(negedge clk);
    chk(err == 1'b0 && !mem_req && !obj_ready, tag, 32'(err), 32'd0);
  endtask

  task automatic run_obj(input logic [31:0] b, input logic [31:0] l, input int sz, input bit noisy);
    logic [31:0] ab;
    ab = b & ~32'h3;
    go(b, l, sz);
    chk(busy == 1'b1 && rd_ptr == ab, "R2 start", rd_ptr, ab);
    settle();
    chk(obj_ready && sys_rdata == memval(ab), "R2 first word", sys_rdata, memval(ab));
    for (int i = 0; i < sz; i++) begin
      logic [31:0] pa;
      pa = ab + 32'(4 * i);
      if (noisy && ($urandom % 3 == 0)) begin
        ack(4'($urandom % 15));
        chk(sys_rdata == memval(pa) && rd_ptr == pa && !busy, "R4 partial write", sys_rdata, memval(pa));
        repeat (2) @(negedge clk);
        chk(sys_rdata == memval(pa), "R3 non-destructive", sys_rdata, memval(pa));
      end
      if (noisy && (i == 0)) begin
        go(ab + 32'h100, ab + 32'h1000, 1);
        chk(rd_ptr == pa && sys_rdata == memval(pa) && !err, "R11 go while active", rd_ptr, pa);
      end
      ack(4'hF);
      if (i == sz - 1) begin
        chk(!obj_ready && rd_ptr == ab && sys_rdata == 32'h0, "R6 last ack", rd_ptr, ab);
      end else begin
        chk(busy && rd_ptr == pa + 32'd4, "R3 advance", rd_ptr, pa + 32'd4);
        if (noisy && ($urandom % 2 == 0)) ack(4'hF);
        settle();
        chk(sys_rdata == memval(pa + 32'd4) && rd_ptr == pa + 32'd4, "R5/R3 next word",
            sys_rdata, memval(pa + 32'd4));
      end
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!obj_ready && !busy && !err && !mem_req && sys_rdata == 0 && rd_ptr == 0,
        "R1 reset", rd_ptr, 32'h0);

    // R7 idle acknowledge
    ack(4'hF);
    chk(rd_ptr == 0 && sys_rdata == 0 && !busy && !obj_ready, "R7 idle ack", rd_ptr, 32'h0);

    // directed: exact-limit single word, misaligned base
    run_obj(32'h0000_1002, 32'h0000_1000, 1, 1'b0);
    run_obj(32'h0000_2000, 32'h0000_2000 + 32'd4 * 5, 6, 1'b1);
    ack(4'hF);
    chk(rd_ptr == 32'h2000 && sys_rdata == 0 && !busy, "R7 ack after end", rd_ptr, 32'h2000);

    // rejections
    expect_reject(32'h0000_3000, 32'h0000_4000, 0, "R8 size zero");
    expect_reject(32'h0000_3000, 32'h0001_3000, 1025, "R9 size too big");
    expect_reject(32'h0000_3000, 32'h0000_3000 + 32'd4 * 6, 8, "R10 past limit");
    expect_reject(32'hFFFF_FFF0, 32'hFFFF_FFFC, 8, "R10 address wrap");

    // largest object
    run_obj(32'h0001_0000, 32'h0001_0000 + 32'd4 * 1023, 1024, 1'b0);

    // constrained random objects
    for (int n = 0; n < 25; n++) begin
      int sz;
      logic [31:0] b, l;
      sz = 1 + int'($urandom % 16);
      b  = $urandom & 32'h000F_FFFF;
      l  = (b & ~32'h3) + 32'(4 * (sz - 1)) + 32'(4 * ($urandom % 3));
      run_obj(b, l, sz, 1'b1);
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule